// File: doc/BRIEF.md
# Zero-Crossing Valley Counter with Overvoltage Latch

This block sits beside the off-time controller of a quasi-resonant flyback converter. Once the power switch turns off, the drain rings. An analog comparator watches the auxiliary-winding sense pin and raises a flag whenever that pin is below roughly 100 mV. The block counts each new entry into that "below" state as one zero crossing. The count saturates at its top value, and it is cleared whenever the driver output goes high.

An external up/down counter chooses which valley should start the next switching cycle. When a crossing brings the count equal to that valley number, the block issues a one-cycle turn-on request.

The same off-time window is used for output overvoltage protection. If the overvoltage comparator stays high for a programmable blanking interval while the switch is off, a fault latches. The fault persists until reset, and no further turn-on requests are issued while it is set.

Both comparator flags are asynchronous and pass through SYNC_STAGES flip-flops. The driver state and the target valley are synchronous to the clock.

Top module: `zc_valley_counter`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, zc_count_o is 0, turn_on_o is 0 and fault_o is 0.
- R2: A low-to-high transition of zc_below_i while drv_i is low counts as one crossing. Each crossing adds exactly one to zc_count_o. The new value is visible SYNC_STAGES+1 clock edges after the input changes.
- R3: zc_count_o saturates at 7 (all ones for CNT_W=3). Further crossings leave it at 7 and never wrap it to 0.
- R4: A low-to-high transition of drv_i clears zc_count_o to 0 on the next clock edge.
- R5: Crossings that reach the detector while drv_i is high are ignored, and zc_count_o is unchanged.
- R6: turn_on_o is a pulse exactly one cycle wide. It rises on the same edge as the count update caused by a crossing that makes zc_count_o equal valley_target_i. A target of 0 never produces a request, and a crossing at saturation produces none.
- R7: fault_o sets when the synchronised ovp_i has been high for BLANK_CYCLES consecutive cycles with drv_i low. A low cycle, or drv_i going high, restarts the interval. Overvoltage seen only while drv_i is high never sets the fault.
- R8: Once set, fault_o stays high until rst_n is asserted. While it is high, turn_on_o stays 0, and crossings still update zc_count_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| zc_below_i | input | 1 | Asynchronous comparator flag, high while the sense pin is below the crossing threshold |
| ovp_i | input | 1 | Asynchronous output-overvoltage comparator flag |
| drv_i | input | 1 | Driver output state, high while the power switch is on |
| valley_target_i | input | CNT_W | Valley number at which the switch should turn on |
| turn_on_o | output | 1 | One-cycle request to turn the switch on |
| zc_count_o | output | CNT_W | Crossings counted in the current off-time |
| fault_o | output | 1 | Latched overvoltage fault |

## Verification
A crossing updates the count and any turn-on pulse SYNC_STAGES+1 edges after zc_below_i rises. The bench therefore samples both at the falling edge that follows that update, and it checks one cycle later that the pulse has gone. A driver rising edge clears the count at the next edge, so the count is checked one falling edge after drv_i rises. The fault appears SYNC_STAGES+BLANK_CYCLES edges after ovp_i rises, and the bench checks it one cycle before that edge, where it must still be low, and exactly at it. All inputs are changed on falling edges, and outputs are compared with counts and pulses that bench functions derive from the number of crossings and the target.

// File: rtl/zc_valley_counter.sv
module zc_valley_counter #(
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = 12,
  parameter int CNT_W        = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_below_i,
  input  logic             ovp_i,
  input  logic             drv_i,
  input  logic [CNT_W-1:0] valley_target_i,
  output logic             turn_on_o,
  output logic [CNT_W-1:0] zc_count_o,
  output logic             fault_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int BW = $clog2(BLANK_CYCLES + 1);
  localparam logic [BW-1:0] BLANK_LAST = BW'(BLANK_CYCLES - 1);

  logic [SYNC_STAGES-1:0] zc_sync, ovp_sync;
  logic zc_prev, drv_prev;
  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0] blank_q;
  logic fault_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_sync  <= '0;
      ovp_sync <= '0;
      zc_prev  <= 1'b0;
      drv_prev <= 1'b0;
    end else begin
      zc_sync  <= {zc_sync[SYNC_STAGES-2:0], zc_below_i};
      ovp_sync <= {ovp_sync[SYNC_STAGES-2:0], ovp_i};
      zc_prev  <= zc_sync[SYNC_STAGES-1];
      drv_prev <= drv_i;
    end
  end

  wire zc_s      = zc_sync[SYNC_STAGES-1];
  wire ovp_s     = ovp_sync[SYNC_STAGES-1];
  wire sw_off    = ~drv_i;
  wire drv_rise  = drv_i & ~drv_prev;
  wire zc_evt    = zc_s & ~zc_prev & sw_off;
  wire can_inc   = zc_evt & (cnt_q != CNT_MAX);
  wire [CNT_W-1:0] cnt_inc = cnt_q + 1'b1;
  wire ovp_run   = sw_off & ovp_s;
  wire fault_set = ovp_run & (blank_q == BLANK_LAST) & ~fault_q;
  wire hit       = can_inc & (cnt_inc == valley_target_i) & ~fault_q & ~fault_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit & ~drv_rise;
      if (drv_rise)     cnt_q <= '0;
      else if (can_inc) cnt_q <= cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_q <= '0;
      fault_q <= 1'b0;
    end else begin
      if (fault_set) fault_q <= 1'b1;
      if (!ovp_run || fault_q) blank_q <= '0;
      else if (blank_q != BLANK_LAST) blank_q <= blank_q + 1'b1;
    end
  end

  assign zc_count_o = cnt_q;
  assign turn_on_o  = pulse_q;
  assign fault_o    = fault_q;

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_rise |=> (zc_count_o == $past(zc_count_o)) || (zc_count_o == $past(zc_count_o) + 1'b1));

  // R3
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_count_o == CNT_MAX) && !drv_rise |=> zc_count_o == CNT_MAX);

  // R4
  drv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_rise |=> zc_count_o == '0);

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_o |=> !turn_on_o);

  // R6
  pulse_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    turn_on_o |-> (zc_count_o != '0) && (zc_count_o != $past(zc_count_o)));

  // R7
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(ovp_s) && !$past(drv_i));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o);

  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !turn_on_o);

endmodule

// File: tb/zc_valley_counter_tb_top.sv
module zc_valley_counter_tb_top;
  localparam int SYNC  = 2;
  localparam int BLANK = 12;
  localparam int CW    = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, zc_below, ovp, drv, turn_on, fault;
  logic [CW-1:0] target, count;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  zc_valley_counter #(.SYNC_STAGES(SYNC), .BLANK_CYCLES(BLANK), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .zc_below_i(zc_below), .ovp_i(ovp), .drv_i(drv),
    .valley_target_i(target), .turn_on_o(turn_on), .zc_count_o(count), .fault_o(fault));

  function automatic int exp_count(int n);
    return (n > 7) ? 7 : n;
  endfunction

  function automatic int exp_pulse(int n, int t, bit f);
    return (!f && t != 0 && n == t) ? 1 : 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic crossing(int n, bit f, int hi_w, int lo_w);
    zc_below = 1'b1;
    nclk(SYNC + 1);
    check("R2 R3 count after crossing", int'(count), exp_count(n));
    check("R6 turn-on pulse", int'(turn_on), exp_pulse(n, int'(target), f));
    nclk(1);
    check("R6 pulse one cycle wide", int'(turn_on), 0);
    nclk(hi_w);
    zc_below = 1'b0;
    nclk(lo_w);
  endtask

  task automatic switch_on();
    nclk(SYNC + 1);
    drv = 1'b1;
    nclk(1);
    check("R4 count cleared by driver rise", int'(count), 0);
    nclk(2);
    drv = 1'b0;
    nclk(1);
  endtask

  task automatic period(int tgt, int ncross, bit f, bit rnd);
    target = CW'(tgt);
    switch_on();
    for (int i = 1; i <= ncross; i++)
      crossing(i, f, rnd ? $urandom_range(0, 2) : 0, rnd ? $urandom_range(1, 3) : 1);
  endtask

  initial begin
    nclk(200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    rst_n = 1'b0; zc_below = 1'b0; ovp = 1'b0; drv = 1'b0; target = '0;
    nclk(3);
    check("R1 count in reset", int'(count), 0);
    check("R1 turn_on in reset", int'(turn_on), 0);
    check("R1 fault in reset", int'(fault), 0);
    rst_n = 1'b1;
    nclk(1);
    check("R1 count after reset", int'(count), 0);
    nclk(1);

    // R3, R6: saturation with a mid target
    period(3, 9, 1'b0, 1'b0);
    // R6: top valley, then target 0
    period(7, 9, 1'b0, 1'b0);
    period(0, 8, 1'b0, 1'b0);

    // R5: crossings during on-time are ignored
    target = 3'd1;
    drv = 1'b1;
    nclk(2);
    for (int i = 0; i < 3; i++) begin
      zc_below = 1'b1; nclk(2); zc_below = 1'b0; nclk(2);
    end
    nclk(SYNC + 1);
    check("R5 count while driver high", int'(count), 0);
    check("R5 no pulse while driver high", int'(turn_on), 0);
    drv = 1'b0;
    nclk(1);

    // R2, R3, R6: random periods
    for (int p = 0; p < 40; p++)
      period($urandom_range(0, 7), $urandom_range(0, 9), 1'b0, 1'b1);

    // R7: overvoltage only during on-time
    drv = 1'b1; ovp = 1'b1;
    nclk(BLANK + 6);
    ovp = 1'b0;
    nclk(SYNC + 2);
    check("R7 ovp during on-time ignored", int'(fault), 0);
    drv = 1'b0;
    nclk(1);
    // R7: pulse one cycle short of the blanking time
    ovp = 1'b1; nclk(BLANK - 1); ovp = 1'b0;
    nclk(SYNC + 3);
    check("R7 short ovp pulse", int'(fault), 0);
    // R7: glitch restarts the interval
    ovp = 1'b1; nclk(BLANK - 2); ovp = 1'b0; nclk(1);
    ovp = 1'b1; nclk(BLANK - 2); ovp = 1'b0;
    nclk(SYNC + 3);
    check("R7 glitch restarts blanking", int'(fault), 0);
    // R7: exact blanking time
    target = 3'd1;
    switch_on();
    ovp = 1'b1;
    nclk(BLANK);
    ovp = 1'b0;
    nclk(SYNC - 1);
    check("R7 fault one cycle early", int'(fault), 0);
    nclk(1);
    check("R7 fault after blanking", int'(fault), 1);

    // R8: fault suppresses requests, counting continues, sticky
    crossing(1, 1'b1, 0, 1);
    crossing(2, 1'b1, 0, 1);
    period(2, 3, 1'b1, 1'b0);
    check("R8 fault sticky across periods", int'(fault), 1);
    rst_n = 1'b0;
    nclk(1);
    check("R8 fault cleared by reset", int'(fault), 0);
    rst_n = 1'b1;
    nclk(2);
    period(1, 2, 1'b0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule